// File: doc/BRIEF.md
# Serial Front-Panel Command Controller

This block sits between a host processor and the actuators of a small appliance's front panel. The host sends single-character orders on a receive-only asynchronous serial line. The controller never answers. It turns each recognised character into one of four kinds of action. The first sets the mode of one of three LEDs (a power LED, a status LED and a board LED). The second starts a short or a long beep. The third raises a power-off request. The fourth fires a hard-reset pulse.

The serial receiver oversamples the line 16 times per bit and passes it through a two-flop synchronizer. It accepts 8-bit characters with no parity and one stop bit. Each LED holds a mode of off, on or flashing. Every flashing LED follows one shared blink generator, so all of them are in phase. A single buzzer timer serves both beep lengths. A frame with a broken stop bit produces no character. A character outside the command set has no effect.

Top module: `fpanel_cmd_ctrl`

## Requirements
- R1: The receiver accepts frames of one low start bit, 8 data bits sent LSB first and one high stop bit. It samples at 16x the bit rate, with the bit rate set by parameter BAUD against the clock rate CLK_HZ. The default is 9600 bit/s.
- R2: A frame whose stop bit samples low is dropped and changes nothing. The receiver then waits for the line to return high before it hunts for a new start bit.
- R3: Character 0x34 ('4') sets the power LED on, 0x35 ('5') sets it flashing and 0x36 ('6') sets it off.
- R4: Character 0x37 ('7') sets the status LED off, 0x38 ('8') sets it on and 0x39 ('9') sets it flashing.
- R5: Character 0x41 ('A') sets the board LED flashing and 0x42 ('B') sets it off.
- R6: A flashing LED is high for FLASH_HALF cycles and low for FLASH_HALF cycles. All flashing LEDs switch in the same cycle.
- R7: Character 0x32 ('2') drives the buzzer high for SHORT_BEEP cycles. Character 0x33 ('3') drives it high for LONG_BEEP cycles.
- R8: A beep character that arrives while the buzzer is sounding restarts the timer with the new length.
- R9: Character 0x31 ('1') raises the power-off request, which then stays high until reset.
- R10: Character 0x43 ('C') raises the hard-reset output for exactly RST_PULSE cycles. It also returns all three LED modes to off, effective in the cycle the pulse begins.
- R11: Every other character value leaves all LED modes, the buzzer, the power-off request and the hard-reset output unchanged.
- R12: After reset all outputs are low and all LED modes are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| pwr_led_o | output | 1 | Power LED drive |
| stat_led_o | output | 1 | Status LED drive |
| brd_led_o | output | 1 | Board LED drive |
| buzzer_o | output | 1 | Buzzer drive |
| poweroff_req_o | output | 1 | Sticky power-off request |
| hard_rst_o | output | 1 | Hard-reset pulse |

## Verification
The bench sends a frame with a low stop bit. A receiver that ignored the stop bit would act on that character. A receiver that did not wait for the line to return high would lose the valid frame that follows. A beep is sent while a long beep is still sounding. If the timer did not restart, the buzzer would stay on past the short length. Bytes just outside the set (0x30, 0x44, lower case, and '4' with bit 7 set) are sent to catch a decoder that ignores some bits. Three LEDs are flashed together and compared cycle by cycle, which catches separate or misaligned blink sources. The pulse width of the hard reset and the clearing of the LED modes are each measured.

// File: rtl/fpanel_pkg.sv
package fpanel_pkg;

    typedef enum logic [1:0] {
        LED_OFF   = 2'd0,
        LED_ON    = 2'd1,
        LED_FLASH = 2'd2
    } led_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        BEEP_NONE,
        BEEP_SHORT,
        BEEP_LONG
    } beep_req_e;

    localparam logic [7:0] CMD_POWEROFF   = 8'h31;
    localparam logic [7:0] CMD_BEEP_SHORT = 8'h32;
    localparam logic [7:0] CMD_BEEP_LONG  = 8'h33;
    localparam logic [7:0] CMD_PWR_ON     = 8'h34;
    localparam logic [7:0] CMD_PWR_FLASH  = 8'h35;
    localparam logic [7:0] CMD_PWR_OFF    = 8'h36;
    localparam logic [7:0] CMD_STAT_OFF   = 8'h37;
    localparam logic [7:0] CMD_STAT_ON    = 8'h38;
    localparam logic [7:0] CMD_STAT_FLASH = 8'h39;
    localparam logic [7:0] CMD_BRD_FLASH  = 8'h41;
    localparam logic [7:0] CMD_BRD_OFF    = 8'h42;
    localparam logic [7:0] CMD_HARD_RST   = 8'h43;

    function automatic logic led_level(led_mode_e mode, logic phase);
        return (mode == LED_ON) || ((mode == LED_FLASH) && phase);
    endfunction

endpackage

// File: rtl/fpanel_uart_rx.sv
module fpanel_uart_rx
    import fpanel_pkg::*;
#(
    parameter int CLK_HZ = 250_000_000,
    parameter int BAUD   = 9600,
    parameter int OSR    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    localparam int TICK_DIV = CLK_HZ / (BAUD * OSR);
    localparam int DIV_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int OSR_W    = $clog2(OSR);
    localparam int MID      = OSR / 2 - 1;

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        rx_state_e        st;
        logic [DIV_W-1:0] div;
        logic [OSR_W-1:0] os;
        logic [2:0]       bit_idx;
        logic [7:0]       shreg;
        logic             vld;
        logic [7:0]       data;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      tick;

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.sync1 = rx_i;
        st_d.sync2 = st_q.sync1;
        tick       = (st_q.div == DIV_W'(TICK_DIV - 1));
        st_d.div   = tick ? '0 : st_q.div + 1'b1;
        if (tick) begin
            unique case (st_q.st)
                RX_IDLE: begin
                    if (!st_q.sync2) begin
                        st_d.st = RX_START;
                        st_d.os = '0;
                    end
                end
                RX_START: begin
                    if (st_q.os == OSR_W'(MID)) begin
                        st_d.os = '0;
                        if (!st_q.sync2) begin
                            st_d.st      = RX_DATA;
                            st_d.bit_idx = '0;
                        end else begin
                            st_d.st = RX_IDLE;
                        end
                    end else begin
                        st_d.os = st_q.os + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (st_q.os == OSR_W'(OSR - 1)) begin
                        st_d.os    = '0;
                        st_d.shreg = {st_q.sync2, st_q.shreg[7:1]};
                        if (st_q.bit_idx == 3'd7) st_d.st = RX_STOP;
                        else st_d.bit_idx = st_q.bit_idx + 1'b1;
                    end else begin
                        st_d.os = st_q.os + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (st_q.os == OSR_W'(OSR - 1)) begin
                        st_d.os = '0;
                        if (st_q.sync2) begin
                            st_d.vld  = 1'b1;
                            st_d.data = st_q.shreg;
                            st_d.st   = RX_IDLE;
                        end else begin
                            st_d.st = RX_HOLD;
                        end
                    end else begin
                        st_d.os = st_q.os + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (st_q.sync2) st_d.st = RX_IDLE;
                end
                default: st_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sync1 <= 1'b1;
            st_q.sync2 <= 1'b1;
            st_q.st    <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld_o = st_q.vld;
    assign byte_o     = st_q.data;
endmodule

// File: rtl/fpanel_flash_gen.sv
module fpanel_flash_gen #(
    parameter int FLASH_HALF = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    localparam int HW = (FLASH_HALF > 1) ? $clog2(FLASH_HALF) : 1;

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          phase;
    } flash_state_t;

    flash_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (fl_q.cnt == HW'(FLASH_HALF - 1)) begin
            fl_d.cnt   = '0;
            fl_d.phase = ~fl_q.phase;
        end else begin
            fl_d.cnt = fl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign phase_o = fl_q.phase;
endmodule

// File: rtl/fpanel_beep_timer.sv
module fpanel_beep_timer
    import fpanel_pkg::*;
#(
    parameter int SHORT_BEEP = 25_000_000,
    parameter int LONG_BEEP  = 250_000_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  beep_req_e req_i,
    output logic      buzz_o
);
    localparam int CW = $clog2(LONG_BEEP + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case (req_i)
            BEEP_SHORT: cnt_d = CW'(SHORT_BEEP);
            BEEP_LONG:  cnt_d = CW'(LONG_BEEP);
            default: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign buzz_o = (cnt_q != '0);
endmodule

// File: rtl/fpanel_cmd_ctrl.sv
module fpanel_cmd_ctrl
    import fpanel_pkg::*;
#(
    parameter int CLK_HZ     = 250_000_000,
    parameter int BAUD       = 9600,
    parameter int FLASH_HALF = 62_500_000,
    parameter int SHORT_BEEP = 25_000_000,
    parameter int LONG_BEEP  = 250_000_000,
    parameter int RST_PULSE  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic pwr_led_o,
    output logic stat_led_o,
    output logic brd_led_o,
    output logic buzzer_o,
    output logic poweroff_req_o,
    output logic hard_rst_o
);
    localparam int RW = $clog2(RST_PULSE + 1);

    typedef struct packed {
        led_mode_e     pwr;
        led_mode_e     stat;
        led_mode_e     brd;
        logic          poweroff;
        logic [RW-1:0] rst_cnt;
    } panel_state_t;

    panel_state_t pn_d, pn_q;
    logic         rx_vld;
    logic [7:0]   rx_byte;
    logic         flash_ph;
    beep_req_e    beep_req;
    led_mode_e    pwr_mode_w, stat_mode_w, brd_mode_w;

    fpanel_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .OSR(16)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .byte_vld_o (rx_vld),
        .byte_o     (rx_byte)
    );

    fpanel_flash_gen #(.FLASH_HALF(FLASH_HALF)) u_flash (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (flash_ph)
    );

    fpanel_beep_timer #(.SHORT_BEEP(SHORT_BEEP), .LONG_BEEP(LONG_BEEP)) u_beep (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (beep_req),
        .buzz_o (buzzer_o)
    );

    always_comb begin
        pn_d     = pn_q;
        beep_req = BEEP_NONE;
        if (pn_q.rst_cnt != '0) pn_d.rst_cnt = pn_q.rst_cnt - 1'b1;
        if (rx_vld) begin
            unique case (rx_byte)
                CMD_POWEROFF:   pn_d.poweroff = 1'b1;
                CMD_BEEP_SHORT: beep_req      = BEEP_SHORT;
                CMD_BEEP_LONG:  beep_req      = BEEP_LONG;
                CMD_PWR_ON:     pn_d.pwr      = LED_ON;
                CMD_PWR_FLASH:  pn_d.pwr      = LED_FLASH;
                CMD_PWR_OFF:    pn_d.pwr      = LED_OFF;
                CMD_STAT_OFF:   pn_d.stat     = LED_OFF;
                CMD_STAT_ON:    pn_d.stat     = LED_ON;
                CMD_STAT_FLASH: pn_d.stat     = LED_FLASH;
                CMD_BRD_FLASH:  pn_d.brd      = LED_FLASH;
                CMD_BRD_OFF:    pn_d.brd      = LED_OFF;
                CMD_HARD_RST: begin
                    pn_d.rst_cnt = RW'(RST_PULSE);
                    pn_d.pwr     = LED_OFF;
                    pn_d.stat    = LED_OFF;
                    pn_d.brd     = LED_OFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pn_q      <= '0;
            pn_q.pwr  <= LED_OFF;
            pn_q.stat <= LED_OFF;
            pn_q.brd  <= LED_OFF;
        end else begin
            pn_q <= pn_d;
        end
    end

    assign pwr_mode_w     = pn_q.pwr;
    assign stat_mode_w    = pn_q.stat;
    assign brd_mode_w     = pn_q.brd;
    assign pwr_led_o      = led_level(pn_q.pwr, flash_ph);
    assign stat_led_o     = led_level(pn_q.stat, flash_ph);
    assign brd_led_o      = led_level(pn_q.brd, flash_ph);
    assign poweroff_req_o = pn_q.poweroff;
    assign hard_rst_o     = (pn_q.rst_cnt != '0);
endmodule

// File: rtl/fpanel_cmd_checker.sv
module fpanel_cmd_checker #(
    parameter int RST_PULSE = 16,
    parameter int LONG_BEEP = 250_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_vld,
    input logic       hard_rst,
    input logic       poweroff_req,
    input logic       buzzer,
    input logic       pwr_led,
    input logic       brd_led,
    input logic [1:0] pwr_mode,
    input logic [1:0] stat_mode,
    input logic [1:0] brd_mode
);
    int unsigned rst_run;
    int unsigned buzz_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_run  <= 0;
            buzz_run <= 0;
        end else begin
            rst_run  <= hard_rst ? rst_run + 1 : 0;
            buzz_run <= buzzer ? buzz_run + 1 : 0;
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R1
    AST_PWR_ON_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd1) |-> pwr_led); // R3
    AST_FLASH_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd2 && brd_mode == 2'd2) |-> (pwr_led == brd_led)); // R6
    AST_BEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        buzzer |-> (buzz_run < LONG_BEEP)); // R7
    AST_POWEROFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_req |=> poweroff_req); // R9
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |-> (rst_run < RST_PULSE)); // R10
    AST_RST_CLEARS_LEDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_rst) |-> (pwr_mode == 2'd0 && stat_mode == 2'd0 && brd_mode == 2'd0)); // R10
endmodule

bind fpanel_cmd_ctrl fpanel_cmd_checker #(
    .RST_PULSE (RST_PULSE),
    .LONG_BEEP (LONG_BEEP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_vld     (rx_vld),
    .hard_rst     (hard_rst_o),
    .poweroff_req (poweroff_req_o),
    .buzzer       (buzzer_o),
    .pwr_led      (pwr_led_o),
    .brd_led      (brd_led_o),
    .pwr_mode     (pwr_mode_w),
    .stat_mode    (stat_mode_w),
    .brd_mode     (brd_mode_w)
);

// File: tb/tb_fpanel_cmd_ctrl.sv
module tb_fpanel_cmd_ctrl;
    localparam int CLK_HZ     = 64_000;
    localparam int BAUD       = 1000;
    localparam int BIT        = 64;
    localparam int FLASH_HALF = 32;
    localparam int SHORT_BEEP = 100;
    localparam int LONG_BEEP  = 3000;
    localparam int RST_PULSE  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic pwr_led, stat_led, brd_led, buzzer, poweroff_req, hard_rst;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int buzz_run = 0, last_buzz = 0;
    int rst_run = 0, last_rst = 0, rst_pulses = 0;

    int mode_pwr = 0, mode_stat = 0, mode_brd = 0;

    always #2 clk = ~clk;

    fpanel_cmd_ctrl #(
        .CLK_HZ(CLK_HZ), .BAUD(BAUD), .FLASH_HALF(FLASH_HALF),
        .SHORT_BEEP(SHORT_BEEP), .LONG_BEEP(LONG_BEEP), .RST_PULSE(RST_PULSE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx),
        .pwr_led_o(pwr_led), .stat_led_o(stat_led), .brd_led_o(brd_led),
        .buzzer_o(buzzer), .poweroff_req_o(poweroff_req), .hard_rst_o(hard_rst)
    );

    always @(negedge clk) begin
        if (buzzer) buzz_run++;
        else if (buzz_run != 0) begin last_buzz = buzz_run; buzz_run = 0; end
        if (hard_rst) rst_run++;
        else if (rst_run != 0) begin last_rst = rst_run; rst_run = 0; rst_pulses++; end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b, bit stop_ok = 1'b1);
        rx = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx = stop_ok;
        repeat (BIT) @(negedge clk);
        rx = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    function automatic logic led_of(int idx);
        return (idx == 0) ? pwr_led : (idx == 1) ? stat_led : brd_led;
    endfunction

    // mode: 0 off, 1 on, 2 flash
    task automatic chk_led(string req, int idx, int mode);
        if (mode == 2) begin
            int hi = 0;
            for (int c = 0; c < 2 * FLASH_HALF; c++) begin
                @(negedge clk);
                if (led_of(idx)) hi++;
            end
            chk(req, hi, FLASH_HALF);
        end else begin
            chk(req, int'(led_of(idx)), mode);
        end
    endtask

    function automatic void model(logic [7:0] b);
        case (b)
            8'h34: mode_pwr = 1;
            8'h35: mode_pwr = 2;
            8'h36: mode_pwr = 0;
            8'h37: mode_stat = 0;
            8'h38: mode_stat = 1;
            8'h39: mode_stat = 2;
            8'h41: mode_brd = 2;
            8'h42: mode_brd = 0;
            8'h43: begin mode_pwr = 0; mode_stat = 0; mode_brd = 0; end
            default: ;
        endcase
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] ign [6];
        logic [7:0] pool [14];
        int pulses0;
        ign = '{8'h30, 8'h44, 8'h61, 8'hB4, 8'h00, 8'hFF};
        pool = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37,
                 8'h38, 8'h39, 8'h41, 8'h42, 8'h43, 8'h5A, 8'h0D};
        void'($urandom(32'h5eed));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12 reset state
        chk("R12 pwr", int'(pwr_led), 0);
        chk("R12 stat", int'(stat_led), 0);
        chk("R12 brd", int'(brd_led), 0);
        chk("R12 buzz", int'(buzzer), 0);
        chk("R12 poff", int'(poweroff_req), 0);
        chk("R12 hrst", int'(hard_rst), 0);

        // R3 / R1 power LED modes
        send(8'h34); chk_led("R3 R1 pwr on", 0, 1);
        send(8'h35); chk_led("R3 pwr flash", 0, 2);
        send(8'h36); chk_led("R3 pwr off", 0, 0);
        // R4 status LED
        send(8'h38); chk_led("R4 stat on", 1, 1);
        send(8'h39); chk_led("R4 stat flash", 1, 2);
        send(8'h37); chk_led("R4 stat off", 1, 0);
        // R5 board LED
        send(8'h41); chk_led("R5 brd flash", 2, 2);
        send(8'h42); chk_led("R5 brd off", 2, 0);

        // R6 shared in-phase flashing
        send(8'h35); send(8'h39); send(8'h41);
        begin
            int mism = 0, edges = 0, hi = 0;
            logic prev;
            @(negedge clk); prev = brd_led;
            for (int c = 0; c < 8 * FLASH_HALF; c++) begin
                @(negedge clk);
                if (pwr_led != brd_led || stat_led != brd_led) mism++;
                if (brd_led != prev) edges++;
                if (brd_led) hi++;
                prev = brd_led;
            end
            chk("R6 phase mismatch", mism, 0);
            chk("R6 toggles", edges, 8);
            chk("R6 duty", hi, 4 * FLASH_HALF);
        end

        // R10 hard reset
        pulses0 = rst_pulses;
        send(8'h43);
        chk("R10 pulse count", rst_pulses - pulses0, 1);
        chk("R10 pulse width", last_rst, RST_PULSE);
        chk_led("R10 pwr cleared", 0, 0);
        chk_led("R10 stat cleared", 1, 0);
        chk_led("R10 brd cleared", 2, 0);

        // R7 beep lengths
        send(8'h32);
        repeat (SHORT_BEEP + 20) @(negedge clk);
        chk("R7 short len", last_buzz, SHORT_BEEP);
        send(8'h33);
        repeat (LONG_BEEP + 20) @(negedge clk);
        chk("R7 long len", last_buzz, LONG_BEEP);
        chk("R7 buzzer idle", int'(buzzer), 0);

        // R8 restart: long then short
        send(8'h33);
        chk("R8 long running", int'(buzzer), 1);
        send(8'h32);
        repeat (SHORT_BEEP) @(negedge clk);
        chk("R8 restarted short", int'(buzzer), 0);

        // R2 bad stop bit, then recovery
        send(8'h34, 1'b0);
        chk_led("R2 bad stop dropped", 0, 0);
        send(8'h34);
        chk_led("R2 recovery", 0, 1);

        // R11 ignored bytes (pwr on, stat off, brd off)
        pulses0 = rst_pulses;
        foreach (ign[k]) begin
            send(ign[k]);
            chk("R11 pwr", int'(pwr_led), 1);
            chk("R11 stat", int'(stat_led), 0);
            chk("R11 brd", int'(brd_led), 0);
            chk("R11 buzz", int'(buzzer), 0);
            chk("R11 poff", int'(poweroff_req), 0);
        end
        chk("R11 no reset pulse", rst_pulses - pulses0, 0);

        // R9 power-off request, sticky
        send(8'h31);
        chk("R9 poff set", int'(poweroff_req), 1);

        // random command mix against the model
        mode_pwr = 1; mode_stat = 0; mode_brd = 0;
        for (int n = 0; n < 25; n++) begin
            logic [7:0] b;
            b = pool[$urandom_range(13, 0)];
            send(b);
            model(b);
            chk_led("R3 rnd pwr", 0, mode_pwr);
            chk_led("R4 rnd stat", 1, mode_stat);
            chk_led("R5 rnd brd", 2, mode_brd);
        end
        chk("R9 poff held", int'(poweroff_req), 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule